// File: doc/BRIEF.md
# Exception-Entry Status and Stack Controller

This block owns a small processor's 16-bit status word and its two stack pointers, one for user mode and one for supervisor mode. When the core signals an exception, the controller does several things in one clock edge. It captures the status word as it stood before the exception, together with the address of the faulting instruction, so that the frame can be stacked and the instruction restarted. It then switches to supervisor mode and turns tracing off. If the exception is an interrupt, it also clears the master bit and raises the interrupt mask to the requesting level. Every exception, of either kind, produces the same frame layout with the same format code.

The block also executes three privileged commands. It can copy the user stack pointer out, load the user stack pointer from an operand, and push the current status word and then reload it from an immediate value. The core can rewrite whichever stack pointer is active through a separate write strobe. Status word layout: trace at bit 15, supervisor at bit 13, master at bit 12, interrupt mask at bits 10:8, condition codes in bits 7:0. Bits 14 and 11 are kept as stored.

Top module: `xcpt_entry_ctl`

## Requirements
- R1: With `rst` high at a clock edge, the status word becomes 16'h2700 (supervisor, trace off, mask 7). Both stack pointers become zero, and `busy`, `frame_valid`, `push_valid`, `usp_rd_valid` and `priv_viol` are 0.
- R2: An accepted exception makes `frame_valid` pulse one cycle after the edge. In that same cycle `stk_sr` holds the status word from before the edge, `saved_pc` holds `fault_pc` as given with the request, and `frame_fmt` holds 4'h4. This is the same for interrupts and for other exceptions.
- R3: After any accepted exception, bit 13 is 1 and bit 15 is 0. For a non-interrupt exception every other bit keeps its prior value.
- R4: After an accepted interrupt (`exc_irq`=1), bit 12 is 0 and bits 10:8 equal `irq_lvl`. The other bits follow R3.
- R5: `active_sp` shows the supervisor pointer when bit 13 is 1 and the user pointer otherwise. `asp_wr` loads `asp_wdata` into the pointer selected by bit 13 as it stood before the edge.
- R6: In supervisor mode, `usp_rd` makes `usp_rd_valid` pulse the next cycle, with `usp_rd_data` equal to the user pointer.
- R7: In supervisor mode, `usp_wr` loads `usp_wdata` into the user pointer and leaves the supervisor pointer unchanged.
- R8: In supervisor mode, `sr_swap` makes `push_valid` pulse the next cycle, with `stk_sr` equal to the prior status word, and loads `imm_sr` into the status word.
- R9: Any of `usp_rd`, `usp_wr` or `sr_swap` issued while bit 13 is 0 makes `priv_viol` pulse the next cycle and changes neither the status word nor the user pointer.
- R10: `busy` is high for exactly the one cycle after an accepted exception. An `exc_req` seen during that cycle is ignored: no frame, no status change.
- R11: When an exception is accepted, any command issued in the same cycle is dropped. It has no effect and raises no `priv_viol`.
- R12: When several commands are issued together in supervisor mode, only one executes: `sr_swap` first, then `usp_wr`, then `usp_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe |
| exc_irq | input | 1 | Request is an interrupt |
| irq_lvl | input | 3 | Interrupt request level |
| fault_pc | input | 32 | Address of the faulting instruction |
| usp_rd | input | 1 | Copy-user-pointer-out command |
| usp_wr | input | 1 | Load-user-pointer command |
| usp_wdata | input | 32 | Operand for `usp_wr` |
| sr_swap | input | 1 | Push-then-reload status command |
| imm_sr | input | 16 | Immediate for `sr_swap` |
| asp_wr | input | 1 | Write the active stack pointer |
| asp_wdata | input | 32 | Data for `asp_wr` |
| sr_out | output | 16 | Current status word |
| super_mode | output | 1 | Current privilege (bit 13) |
| active_sp | output | 32 | Stack pointer selected by mode |
| busy | output | 1 | Entry update in progress |
| frame_valid | output | 1 | Exception frame data valid |
| push_valid | output | 1 | Status push data valid |
| stk_sr | output | 16 | Status word to be stacked |
| saved_pc | output | 32 | Restart address for the frame |
| frame_fmt | output | 4 | Fixed frame format code |
| usp_rd_data | output | 32 | User pointer read result |
| usp_rd_valid | output | 1 | Read result valid |
| priv_viol | output | 1 | Privilege violation pulse |

## Verification
An exception entry and a privileged command can arrive in the same cycle, and both would write the status word or the user pointer. The bench issues this collision in supervisor mode, pairing an exception with a user-pointer load, and in user mode, pairing an interrupt with a status reload. A collision passes only if the status word equals the entry value, the user pointer read back afterwards is unchanged, and no violation pulse appears. A separate sweep runs every interrupt level, for both request kinds, from several starting status words, and it also retries a request in the busy cycle.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

    typedef struct packed {
        logic       trace;    // bit 15
        logic       rsv14;
        logic       sup;      // bit 13
        logic       master;   // bit 12
        logic       rsv11;
        logic [2:0] ipl;      // bits 10:8
        logic [7:0] ccr;      // bits 7:0
    } sr_t;

    localparam logic [15:0] SR_RESET = 16'h2700;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SR_SWAP = 2'd1,
        OP_USP_WR  = 2'd2,
        OP_USP_RD  = 2'd3
    } op_e;

    function automatic sr_t entry_sr(input sr_t cur, input logic irq, input logic [2:0] lvl);
        sr_t nxt;
        nxt       = cur;
        nxt.sup   = 1'b1;
        nxt.trace = 1'b0;
        if (irq) begin
            nxt.master = 1'b0;
            nxt.ipl    = lvl;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/xcpt_cmd_arb.sv
module xcpt_cmd_arb
    import xcpt_pkg::*;
(
    input  logic exc_take,
    input  logic sup,
    input  logic do_swap,
    input  logic do_usp_wr,
    input  logic do_usp_rd,
    output op_e  op,
    output logic viol
);
    logic any_cmd;
    assign any_cmd = do_swap | do_usp_wr | do_usp_rd;

    always_comb begin
        op   = OP_NONE;
        viol = 1'b0;
        if (!exc_take && any_cmd) begin
            if (!sup)           viol = 1'b1;
            else if (do_swap)   op   = OP_SR_SWAP;
            else if (do_usp_wr) op   = OP_USP_WR;
            else                op   = OP_USP_RD;
        end
    end
endmodule

// File: rtl/xcpt_sr_unit.sv
module xcpt_sr_unit
    import xcpt_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          FMT_W    = 4,
    parameter logic [3:0]  FMT_CODE = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_req,
    input  logic             exc_irq,
    input  logic [2:0]       irq_lvl,
    input  logic [AW-1:0]    fault_pc,
    input  op_e              op,
    input  logic [15:0]      imm_sr,
    output logic             exc_take,
    output sr_t              sr_q,
    output logic             busy_q,
    output logic             frame_valid,
    output logic             push_valid,
    output sr_t              stk_sr,
    output logic [AW-1:0]    saved_pc,
    output logic [FMT_W-1:0] frame_fmt
);
    assign exc_take = exc_req && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q        <= sr_t'(SR_RESET);
            busy_q      <= 1'b0;
            frame_valid <= 1'b0;
            push_valid  <= 1'b0;
            stk_sr      <= '0;
            saved_pc    <= '0;
            frame_fmt   <= '0;
        end else begin
            busy_q      <= exc_take;
            frame_valid <= exc_take;
            push_valid  <= (op == OP_SR_SWAP);
            if (exc_take) begin
                stk_sr    <= sr_q;
                saved_pc  <= fault_pc;
                frame_fmt <= FMT_W'(FMT_CODE);
                sr_q      <= entry_sr(sr_q, exc_irq, irq_lvl);
            end else if (op == OP_SR_SWAP) begin
                stk_sr <= sr_q;
                sr_q   <= sr_t'(imm_sr);
            end
        end
    end

    // R2
    frame_copy_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> frame_valid && stk_sr == $past(sr_q) && saved_pc == $past(fault_pc));

    // R3
    entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> sr_q.sup && !sr_q.trace);

    // R4
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take && exc_irq |=> !sr_q.master && sr_q.ipl == $past(irq_lvl));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !busy_q && !frame_valid);

    // R8
    swap_load_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_SR_SWAP |=> push_valid && sr_q == $past(sr_t'(imm_sr)) && stk_sr == $past(sr_q));
endmodule

// File: rtl/xcpt_sp_bank.sv
module xcpt_sp_bank
    import xcpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sup,
    input  op_e           op,
    input  logic [AW-1:0] usp_wdata,
    input  logic          asp_wr,
    input  logic [AW-1:0] asp_wdata,
    output logic [AW-1:0] active_sp,
    output logic [AW-1:0] usp_rd_data,
    output logic          usp_rd_valid
);
    logic [AW-1:0] usp_q;
    logic [AW-1:0] ssp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            usp_q        <= '0;
            ssp_q        <= '0;
            usp_rd_data  <= '0;
            usp_rd_valid <= 1'b0;
        end else begin
            usp_rd_valid <= (op == OP_USP_RD);
            if (op == OP_USP_RD) usp_rd_data <= usp_q;
            if (op == OP_USP_WR)        usp_q <= usp_wdata;
            else if (asp_wr && !sup)    usp_q <= asp_wdata;
            if (asp_wr && sup)          ssp_q <= asp_wdata;
        end
    end

    assign active_sp = sup ? ssp_q : usp_q;

    // R7
    usp_load_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_USP_WR |=> usp_q == $past(usp_wdata) && $stable(ssp_q));

    // R5
    ssp_write_chk: assert property (@(posedge clk) disable iff (rst)
        asp_wr && sup |=> ssp_q == $past(asp_wdata));

    // R6
    usp_read_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_USP_RD |=> usp_rd_valid && usp_rd_data == $past(usp_q));
endmodule

// File: rtl/xcpt_entry_ctl.sv
module xcpt_entry_ctl
    import xcpt_pkg::*;
#(
    parameter int         AW       = 32,
    parameter int         FMT_W    = 4,
    parameter logic [3:0] FMT_CODE = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_req,
    input  logic             exc_irq,
    input  logic [2:0]       irq_lvl,
    input  logic [AW-1:0]    fault_pc,
    input  logic             usp_rd,
    input  logic             usp_wr,
    input  logic [AW-1:0]    usp_wdata,
    input  logic             sr_swap,
    input  logic [15:0]      imm_sr,
    input  logic             asp_wr,
    input  logic [AW-1:0]    asp_wdata,
    output logic [15:0]      sr_out,
    output logic             super_mode,
    output logic [AW-1:0]    active_sp,
    output logic             busy,
    output logic             frame_valid,
    output logic             push_valid,
    output logic [15:0]      stk_sr,
    output logic [AW-1:0]    saved_pc,
    output logic [FMT_W-1:0] frame_fmt,
    output logic [AW-1:0]    usp_rd_data,
    output logic             usp_rd_valid,
    output logic             priv_viol
);
    sr_t  sr_cur;
    sr_t  stk_word;
    op_e  op;
    logic exc_take;
    logic viol;
    logic viol_q;

    xcpt_cmd_arb u_arb (
        .exc_take  (exc_take),
        .sup       (sr_cur.sup),
        .do_swap   (sr_swap),
        .do_usp_wr (usp_wr),
        .do_usp_rd (usp_rd),
        .op        (op),
        .viol      (viol)
    );

    xcpt_sr_unit #(.AW(AW), .FMT_W(FMT_W), .FMT_CODE(FMT_CODE)) u_sr (
        .clk         (clk),
        .rst         (rst),
        .exc_req     (exc_req),
        .exc_irq     (exc_irq),
        .irq_lvl     (irq_lvl),
        .fault_pc    (fault_pc),
        .op          (op),
        .imm_sr      (imm_sr),
        .exc_take    (exc_take),
        .sr_q        (sr_cur),
        .busy_q      (busy),
        .frame_valid (frame_valid),
        .push_valid  (push_valid),
        .stk_sr      (stk_word),
        .saved_pc    (saved_pc),
        .frame_fmt   (frame_fmt)
    );

    xcpt_sp_bank #(.AW(AW)) u_sp (
        .clk          (clk),
        .rst          (rst),
        .sup          (sr_cur.sup),
        .op           (op),
        .usp_wdata    (usp_wdata),
        .asp_wr       (asp_wr),
        .asp_wdata    (asp_wdata),
        .active_sp    (active_sp),
        .usp_rd_data  (usp_rd_data),
        .usp_rd_valid (usp_rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= viol;
    end

    assign sr_out     = sr_cur;
    assign stk_sr     = stk_word;
    assign super_mode = sr_cur.sup;
    assign priv_viol  = viol_q;

    // R9
    viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        viol_q |-> $stable(sr_cur) && !usp_rd_valid && !push_valid);

    // R11
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> !priv_viol && !push_valid && !usp_rd_valid);
endmodule

// File: tb/tb_xcpt_entry_ctl.sv
module tb_xcpt_entry_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req, exc_irq;
    logic [2:0]  irq_lvl;
    logic [31:0] fault_pc;
    logic        usp_rd, usp_wr, sr_swap, asp_wr;
    logic [31:0] usp_wdata, asp_wdata;
    logic [15:0] imm_sr;
    logic [15:0] sr_out, stk_sr;
    logic        super_mode, busy, frame_valid, push_valid, usp_rd_valid, priv_viol;
    logic [31:0] active_sp, saved_pc, usp_rd_data;
    logic [3:0]  frame_fmt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xcpt_entry_ctl dut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_irq(exc_irq), .irq_lvl(irq_lvl),
        .fault_pc(fault_pc), .usp_rd(usp_rd), .usp_wr(usp_wr), .usp_wdata(usp_wdata),
        .sr_swap(sr_swap), .imm_sr(imm_sr), .asp_wr(asp_wr), .asp_wdata(asp_wdata),
        .sr_out(sr_out), .super_mode(super_mode), .active_sp(active_sp), .busy(busy),
        .frame_valid(frame_valid), .push_valid(push_valid), .stk_sr(stk_sr),
        .saved_pc(saved_pc), .frame_fmt(frame_fmt), .usp_rd_data(usp_rd_data),
        .usp_rd_valid(usp_rd_valid), .priv_viol(priv_viol)
    );

    localparam logic [31:0] SSP0 = 32'h1000_0000;
    localparam logic [31:0] USP0 = 32'h2000_0040;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        exc_req = 0; exc_irq = 0; irq_lvl = 0; fault_pc = 0;
        usp_rd = 0; usp_wr = 0; sr_swap = 0; asp_wr = 0;
        usp_wdata = 0; asp_wdata = 0; imm_sr = 0;
    endtask

    task automatic read_usp(input string req, input logic [31:0] exp);
        usp_rd = 1;
        cyc();
        usp_rd = 0;
        chk({req, " rd_valid"}, {31'd0, usp_rd_valid}, 1);
        chk({req, " usp"}, usp_rd_data, exp);
    endtask

    function automatic logic [15:0] entry_exp(input logic [15:0] s, input logic irq, input logic [2:0] l);
        logic [15:0] e;
        e = (s & 16'h7FFF) | 16'h2000;
        if (irq) e = (e & 16'hE8FF) | ({13'd0, l} << 8);
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] starts [4];
        logic [15:0] cur;
        starts[0] = 16'h2700; starts[1] = 16'hB51A;
        starts[2] = 16'h0000; starts[3] = 16'h9F3C;
        idle();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        // R1 reset state
        chk("R1 sr", sr_out, 16'h2700);
        chk("R1 super", super_mode, 1);
        chk("R1 sp", active_sp, 0);
        chk("R1 flags", {busy, frame_valid, push_valid, usp_rd_valid, priv_viol}, 0);

        // R5 supervisor pointer write, R7 user pointer load
        asp_wr = 1; asp_wdata = SSP0; cyc(); idle();
        chk("R5 ssp", active_sp, SSP0);
        usp_wr = 1; usp_wdata = USP0; cyc(); idle();
        chk("R7 ssp kept", active_sp, SSP0);
        read_usp("R6 R7", USP0);

        cur = 16'h2700;
        for (int k = 0; k < 4; k++) begin
            for (int irq = 0; irq < 2; irq++) begin
                for (int l = 0; l < 8; l++) begin
                    logic [15:0] e;
                    logic [31:0] pc;
                    sr_swap = 1; imm_sr = starts[k]; cyc(); idle();
                    chk("R8 push", {31'd0, push_valid}, 1);
                    chk("R8 old", stk_sr, cur);
                    chk("R8 sr", sr_out, starts[k]);
                    chk("R5 sel", active_sp, starts[k][13] ? SSP0 : USP0);
                    pc = 32'h0004_0000 + 32'(k * 64 + irq * 16 + l * 2);
                    exc_req = 1; exc_irq = irq[0]; irq_lvl = l[2:0]; fault_pc = pc;
                    cyc(); idle();
                    e = entry_exp(starts[k], irq[0], l[2:0]);
                    chk("R2 frame", {31'd0, frame_valid}, 1);
                    chk("R2 stk", stk_sr, starts[k]);
                    chk("R2 pc", saved_pc, pc);
                    chk("R2 fmt", frame_fmt, 4'h4);
                    chk(irq ? "R4 sr" : "R3 sr", sr_out, e);
                    chk("R10 busy", {31'd0, busy}, 1);
                    exc_req = 1; exc_irq = 1; irq_lvl = ~l[2:0]; fault_pc = 32'hFFFF_0000;
                    cyc(); idle();
                    chk("R10 drop sr", sr_out, e);
                    chk("R10 drop frame", {busy, frame_valid}, 0);
                    cur = e;
                end
            end
        end

        // R9 user mode commands are refused
        sr_swap = 1; imm_sr = 16'h0004; cyc(); idle();
        asp_wr = 1; asp_wdata = 32'h3000_0010; cyc(); idle();
        chk("R5 usp via asp", active_sp, 32'h3000_0010);
        usp_wr = 1; usp_wdata = 32'hDEAD_0000; cyc(); idle();
        chk("R9 viol wr", {31'd0, priv_viol}, 1);
        usp_rd = 1; cyc(); idle();
        chk("R9 viol rd", {priv_viol, usp_rd_valid}, 2'b10);
        sr_swap = 1; imm_sr = 16'h2700; cyc(); idle();
        chk("R9 viol swap", {priv_viol, push_valid}, 2'b10);
        chk("R9 sr kept", sr_out, 16'h0004);
        chk("R9 usp kept", active_sp, 32'h3000_0010);
        exc_req = 1; cyc(); idle();
        chk("R3 from user", sr_out, 16'h2004);
        chk("R5 ssp kept", active_sp, SSP0);
        read_usp("R9", 32'h3000_0010);

        // R11 collisions
        exc_req = 1; usp_wr = 1; usp_wdata = 32'h5555_0000; cyc(); idle();
        chk("R11 no viol", {31'd0, priv_viol}, 0);
        read_usp("R11", 32'h3000_0010);
        sr_swap = 1; imm_sr = 16'h0000; cyc(); idle();
        exc_req = 1; exc_irq = 1; irq_lvl = 3; sr_swap = 1; imm_sr = 16'hFFFF; cyc(); idle();
        chk("R11 sr", sr_out, 16'h2300);
        chk("R11 flags", {frame_valid, push_valid, priv_viol}, 3'b100);
        cyc();

        // R12 priority
        sr_swap = 1; imm_sr = 16'h2155; usp_wr = 1; usp_wdata = 32'h7777_0000; cyc(); idle();
        chk("R12 swap", sr_out, 16'h2155);
        read_usp("R12 swap over wr", 32'h3000_0010);
        usp_wr = 1; usp_wdata = 32'h6666_0000; usp_rd = 1; cyc(); idle();
        chk("R12 rd suppressed", {31'd0, usp_rd_valid}, 0);
        read_usp("R12 wr over rd", 32'h6666_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule